// File: doc/BRIEF.md
# Page-Aware Four-Port Priority Arbiter

This block decides which of four requesting ports is handed to a single SDRAM command engine. Port 0 always has the strongest claim and port 3 the weakest. The block keeps a record of the open row in each bank. When the winning request can be served at once because its row is already open, it is granted directly. When that row is closed, the block first asks for a row activation. If another row occupies the bank, it asks for a precharge and then an activation. After either request it waits a set number of cycles before it grants.

While a higher port waits for its row to open, the block may slip in one lower-priority port whose row is already open in a different bank. This uses the activation delay instead of leaving it idle. At most one such access goes in per activation, so the waiting port cannot be starved. After that the waiting port is served ahead of all other ports.

The controller is a state machine with seven states. `ST_IDLE` evaluates the pending requests. `ST_PRECH` issues a one-cycle precharge pulse and `ST_PRE_WAIT` counts out the precharge delay. `ST_ACTV` issues a one-cycle activate pulse and records the new open row. `ST_ACT_WAIT` counts out the activation delay. `ST_FILL` holds the grant of an inserted lower-port access. `ST_SERVE` holds the grant of a normal access.

The transitions are as follows:
- `ST_IDLE` goes to `ST_SERVE` on a page hit, to `ST_PRECH` on a row conflict, and to `ST_ACTV` on a closed bank.
- `ST_PRECH` goes to `ST_PRE_WAIT`, and `ST_PRE_WAIT` goes to `ST_ACTV` when its count reaches zero.
- `ST_ACTV` goes to `ST_ACT_WAIT`.
- `ST_ACT_WAIT` goes to `ST_SERVE` when its count reaches zero. Before that it goes to `ST_FILL` if an insertion is allowed.
- `ST_FILL` returns to `ST_ACT_WAIT` on done.
- `ST_SERVE` returns to `ST_IDLE` on done.

A requesting port holds its bank, row and write flag steady until it sees done.

Top module: `pgarb_top`

## Requirements
- R1: With the block idle and only page-hit requests pending, the lowest-numbered requesting port is granted in the cycle after the requests appear. The remaining ports follow in ascending order, each granted three cycles after the previous grant when done arrives one cycle after each grant.
- R2: A winning request to a closed bank produces a one-cycle `act_o` pulse carrying its bank and row. Its grant follows ACT_DLY+1 cycles after that pulse when nothing is inserted.
- R3: A winning request to a bank whose open row differs produces a one-cycle `pre_o` pulse for that bank. An `act_o` for the bank follows PRE_DLY+1 cycles later, then the grant follows as in R2. An activate is only ever issued to a closed bank.
- R4: `gnt_o` is one-hot or zero. A grant holds until `done_i` is high in the bit of the granted port. Done bits of other ports have no effect.
- R5: During an activation wait, the lowest-numbered lower-priority port whose row is open in another bank is granted two cycles after `act_o`. The waiting port is granted at the later of two cycles: ACT_DLY+1 cycles after `act_o`, or the cycle after the inserted access completes and the block passes back through `ST_ACT_WAIT`.
- R6: At most one access is inserted per activation. Any further lower ports wait until the higher port is served.
- R7: A port of higher priority than the waiting port is never inserted, even when its row is open.
- R8: A lower port that targets the bank being activated is not inserted, even when it asks for the row being opened.
- R9: `gnt_wr_o` equals the write flag of the granted port while the grant is high.
- R10: During and after reset no grant, precharge or activate is asserted, and every bank is recorded as closed. The first request to any bank therefore activates without a precharge.
- R11: After a row is opened and served, a later request to the same row is granted in the next cycle with no precharge or activate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | NPORT | Request per port, held until done |
| bank_i | input | NPORT*BANK_W | Target bank of each port, port p at bits p*BANK_W upward |
| row_i | input | NPORT*ROW_W | Target row of each port, port p at bits p*ROW_W upward |
| wr_i | input | NPORT | Write flag per port |
| done_i | input | NPORT | Engine completion pulse per port |
| gnt_o | output | NPORT | One-hot grant |
| gnt_wr_o | output | 1 | Write flag of the granted port |
| pre_o | output | 1 | Precharge request pulse |
| pre_bank_o | output | BANK_W | Bank to precharge |
| act_o | output | 1 | Activate request pulse |
| act_bank_o | output | BANK_W | Bank to activate |
| act_row_o | output | ROW_W | Row to activate |

## Verification
A corrupted open-row record shows at the ports within one cycle of the next request to that bank. The request then draws a spurious precharge or activate where a direct grant was due, or a direct grant where an activate was due. A miscounted delay shifts the grant of the waiting port by whole cycles against the `act_o` or `pre_o` pulse, so the bench measures every gap in cycles. A wrong insertion decision appears as a changed grant order among the ports. The bench checks that order in full for every ordered pair of ports and for every request mask.

// File: rtl/pgarb_pkg.sv
package pgarb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_PRECH    = 3'd1,
        ST_PRE_WAIT = 3'd2,
        ST_ACTV     = 3'd3,
        ST_ACT_WAIT = 3'd4,
        ST_FILL     = 3'd5,
        ST_SERVE    = 3'd6
    } arb_state_e;

endpackage

// File: rtl/pgarb_prio.sv
// Fixed-priority picker: the lowest set index wins.
module pgarb_prio #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]  cand,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (cand[i]) begin
                any = 1'b1;
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/pgarb_rowtab.sv
// Open-row record per bank and page-hit / row-conflict lookup per port.
module pgarb_rowtab #(
    parameter int NPORT  = 4,
    parameter int NBANK  = 4,
    parameter int ROW_W  = 4,
    parameter int BANK_W = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    open_en,
    input  logic [BANK_W-1:0]       open_bank,
    input  logic [ROW_W-1:0]        open_row,
    input  logic                    close_en,
    input  logic [BANK_W-1:0]       close_bank,
    input  logic [NPORT*BANK_W-1:0] port_bank,
    input  logic [NPORT*ROW_W-1:0]  port_row,
    output logic [NPORT-1:0]        hit,
    output logic [NPORT-1:0]        conflict,
    output logic [NBANK-1:0]        bank_open
);
    logic [ROW_W-1:0] row_q [NBANK];
    logic [NBANK-1:0] vld_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
            for (int b = 0; b < NBANK; b++) row_q[b] <= '0;
        end else begin
            if (close_en) vld_q[close_bank] <= 1'b0;
            if (open_en) begin
                vld_q[open_bank] <= 1'b1;
                row_q[open_bank] <= open_row;
            end
        end
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_lookup
        logic [BANK_W-1:0] pb;
        logic [ROW_W-1:0]  pr;
        assign pb          = port_bank[p*BANK_W +: BANK_W];
        assign pr          = port_row[p*ROW_W +: ROW_W];
        assign hit[p]      = vld_q[pb] && (row_q[pb] == pr);
        assign conflict[p] = vld_q[pb] && (row_q[pb] != pr);
    end

    assign bank_open = vld_q;

    // Opening and closing come from different FSM states and never coincide.
    assert_open_close_apart_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(open_en && close_en));
endmodule

// File: rtl/pgarb_delay.sv
// Down-counter for precharge and activation waits.
module pgarb_delay #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    output logic             zero
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)                    cnt_q <= '0;
        else if (load)                 cnt_q <= load_val;
        else if (tick && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/pgarb_top.sv
module pgarb_top
    import pgarb_pkg::*;
#(
    parameter int NPORT   = 4,
    parameter int NBANK   = 4,
    parameter int ROW_W   = 4,
    parameter int ACT_DLY = 3,
    parameter int PRE_DLY = 2,
    localparam int BANK_W = $clog2(NBANK),
    localparam int PIDX_W = $clog2(NPORT),
    localparam int DMAX   = (ACT_DLY > PRE_DLY) ? ACT_DLY : PRE_DLY,
    localparam int CNT_W  = $clog2(DMAX + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NPORT-1:0]        req_i,
    input  logic [NPORT*BANK_W-1:0] bank_i,
    input  logic [NPORT*ROW_W-1:0]  row_i,
    input  logic [NPORT-1:0]        wr_i,
    input  logic [NPORT-1:0]        done_i,
    output logic [NPORT-1:0]        gnt_o,
    output logic                    gnt_wr_o,
    output logic                    pre_o,
    output logic [BANK_W-1:0]       pre_bank_o,
    output logic                    act_o,
    output logic [BANK_W-1:0]       act_bank_o,
    output logic [ROW_W-1:0]        act_row_o
);
    arb_state_e        state_q, state_d;
    logic [PIDX_W-1:0] pend_q, pend_d;
    logic [PIDX_W-1:0] cur_q, cur_d;
    logic [BANK_W-1:0] pbank_q, pbank_d;
    logic [ROW_W-1:0]  prow_q, prow_d;
    logic              ins_q, ins_d;

    logic [NPORT-1:0]  hit, conflict, lo_cand;
    logic [NBANK-1:0]  bank_open;
    logic              top_any, lo_any, dly_zero, dly_load, dly_tick;
    logic [PIDX_W-1:0] top_idx, lo_idx;
    logic [CNT_W-1:0]  dly_val;

    pgarb_prio #(.N(NPORT), .IW(PIDX_W)) u_top_pick (
        .cand(req_i), .any(top_any), .idx(top_idx)
    );

    // Lower ports that hit an open row in a bank other than the one being opened.
    for (genvar p = 0; p < NPORT; p++) begin : g_lo
        assign lo_cand[p] = req_i[p] && hit[p] && (PIDX_W'(p) > pend_q)
                            && (bank_i[p*BANK_W +: BANK_W] != pbank_q);
    end

    pgarb_prio #(.N(NPORT), .IW(PIDX_W)) u_lo_pick (
        .cand(lo_cand), .any(lo_any), .idx(lo_idx)
    );

    pgarb_rowtab #(.NPORT(NPORT), .NBANK(NBANK), .ROW_W(ROW_W), .BANK_W(BANK_W)) u_rowtab (
        .clk(clk), .rst_n(rst_n),
        .open_en(state_q == ST_ACTV), .open_bank(pbank_q), .open_row(prow_q),
        .close_en(state_q == ST_PRECH), .close_bank(pbank_q),
        .port_bank(bank_i), .port_row(row_i),
        .hit(hit), .conflict(conflict), .bank_open(bank_open)
    );

    assign dly_load = (state_q == ST_PRECH) || (state_q == ST_ACTV);
    assign dly_val  = (state_q == ST_ACTV) ? CNT_W'(ACT_DLY - 1) : CNT_W'(PRE_DLY - 1);
    assign dly_tick = (state_q == ST_PRE_WAIT) || (state_q == ST_ACT_WAIT) || (state_q == ST_FILL);

    pgarb_delay #(.CNT_W(CNT_W)) u_delay (
        .clk(clk), .rst_n(rst_n), .load(dly_load), .load_val(dly_val),
        .tick(dly_tick), .zero(dly_zero)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pend_q  <= '0;
            cur_q   <= '0;
            pbank_q <= '0;
            prow_q  <= '0;
            ins_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            pend_q  <= pend_d;
            cur_q   <= cur_d;
            pbank_q <= pbank_d;
            prow_q  <= prow_d;
            ins_q   <= ins_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        pend_d  = pend_q;
        cur_d   = cur_q;
        pbank_d = pbank_q;
        prow_d  = prow_q;
        ins_d   = ins_q;
        unique case (state_q)
            ST_IDLE: begin
                if (top_any) begin
                    if (hit[top_idx]) begin
                        state_d = ST_SERVE;
                        cur_d   = top_idx;
                    end else begin
                        state_d = conflict[top_idx] ? ST_PRECH : ST_ACTV;
                        pend_d  = top_idx;
                        pbank_d = bank_i[top_idx*BANK_W +: BANK_W];
                        prow_d  = row_i[top_idx*ROW_W +: ROW_W];
                    end
                end
            end
            ST_PRECH:    state_d = ST_PRE_WAIT;
            ST_PRE_WAIT: if (dly_zero) state_d = ST_ACTV;
            ST_ACTV: begin
                state_d = ST_ACT_WAIT;
                ins_d   = 1'b0;
            end
            ST_ACT_WAIT: begin
                if (dly_zero) begin
                    state_d = ST_SERVE;
                    cur_d   = pend_q;
                end else if (!ins_q && lo_any) begin
                    state_d = ST_FILL;
                    cur_d   = lo_idx;
                    ins_d   = 1'b1;
                end
            end
            ST_FILL:  if (done_i[cur_q]) state_d = ST_ACT_WAIT;
            ST_SERVE: if (done_i[cur_q]) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Output logic
    always_comb begin
        gnt_o      = '0;
        gnt_wr_o   = 1'b0;
        pre_o      = 1'b0;
        act_o      = 1'b0;
        pre_bank_o = pbank_q;
        act_bank_o = pbank_q;
        act_row_o  = prow_q;
        unique case (state_q)
            ST_PRECH: pre_o = 1'b1;
            ST_ACTV:  act_o = 1'b1;
            ST_FILL, ST_SERVE: begin
                gnt_o    = NPORT'(1) << cur_q;
                gnt_wr_o = wr_i[cur_q];
            end
            default: ;
        endcase
    end

    // Checker state: inserted accesses since the last activate.
    logic [1:0] fill_cnt_q;
    logic       was_fill_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_cnt_q <= '0;
            was_fill_q <= 1'b0;
        end else begin
            was_fill_q <= (state_q == ST_FILL);
            if (act_o)
                fill_cnt_q <= '0;
            else if (state_q == ST_FILL && !was_fill_q && fill_cnt_q != 2'd3)
                fill_cnt_q <= fill_cnt_q + 2'd1;
        end
    end

    assert_gnt_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_o));

    assert_gnt_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((|gnt_o) && !(|(done_i & gnt_o))) |=> (gnt_o == $past(gnt_o)));

    assert_gnt_page_open_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (|gnt_o) |-> hit[cur_q]);

    assert_act_bank_closed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        act_o |-> !bank_open[act_bank_o]);

    assert_one_insert_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fill_cnt_q < 2'd2);

    assert_insert_lower_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FILL) |-> (cur_q > pend_q));

    assert_no_pre_act_overlap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pre_o |=> !act_o);
endmodule

// File: tb/pgarb_top_tb_top.sv
module pgarb_top_tb_top;
    localparam int NP = 4;
    localparam int AD = 3;
    localparam int PD = 2;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  req_r, wr_r, done_r;
    logic [7:0]  bank_r;
    logic [15:0] row_r;
    logic [3:0]  gnt_o;
    logic        gnt_wr_o, pre_o, act_o;
    logic [1:0]  pre_bank_o, act_bank_o;
    logic [3:0]  act_row_o;

    always #4 clk = ~clk;

    pgarb_top #(.NPORT(NP), .NBANK(4), .ROW_W(4), .ACT_DLY(AD), .PRE_DLY(PD)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_i(req_r), .bank_i(bank_r), .row_i(row_r),
        .wr_i(wr_r), .done_i(done_r), .gnt_o(gnt_o), .gnt_wr_o(gnt_wr_o),
        .pre_o(pre_o), .pre_bank_o(pre_bank_o), .act_o(act_o),
        .act_bank_o(act_bank_o), .act_row_o(act_row_o)
    );

    int n_chk = 0, n_fail = 0, cyc = 0, n_ev = 0, hold = 0;
    int ev_k [32];
    int ev_v [32];
    int ev_c [32];
    int cur_row [4];
    logic [3:0] gnt_prev = '0;
    bit auto_on = 1'b1;
    bit ended = 1'b0;

    function automatic int imax(int a, int b);
        return (a > b) ? a : b;
    endfunction

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic add_ev(int k, int v);
        if (n_ev < 32) begin
            ev_k[n_ev] = k;
            ev_v[n_ev] = v;
            ev_c[n_ev] = cyc;
            n_ev++;
        end
    endtask

    task automatic clear_log();
        n_ev = 0;
        for (int i = 0; i < 32; i++) begin
            ev_k[i] = -1;
            ev_v[i] = -1;
            ev_c[i] = 0;
        end
    endtask

    // One cycle: sample after the falling edge, log pulses and grants, answer grants.
    task automatic step();
        int idx;
        @(negedge clk);
        cyc++;
        done_r = '0;
        if (pre_o) add_ev(0, int'(pre_bank_o));
        if (act_o) add_ev(1, int'(act_bank_o));
        if (gnt_o != 0 && gnt_o != gnt_prev) begin
            idx = 0;
            for (int i = 0; i < NP; i++) if (gnt_o[i]) idx = i;
            add_ev(2, idx);
            check("R4 grant one-hot", $countones(gnt_o), 1);
            check("R9 write flag", int'(gnt_wr_o), int'(wr_r[idx]));
            hold = 1;
        end else if (gnt_o != 0 && auto_on && hold == 1) begin
            done_r = gnt_o;
            req_r  = req_r & ~gnt_o;
            hold   = 0;
        end
        gnt_prev = gnt_o;
    endtask

    task automatic set_port(int p, int b, int r, bit w);
        bank_r[p*2 +: 2] = 2'(b);
        row_r[p*4 +: 4]  = 4'(r);
        wr_r[p]          = w;
        req_r[p]         = 1'b1;
    endtask

    task automatic drain();
        int g = 0;
        while (req_r != 0 && g < 300) begin
            step();
            g++;
        end
        repeat (3) step();
    endtask

    task automatic exp_ev(string tag, int i, int k, int v);
        check({tag, " kind"}, ev_k[i], k);
        check({tag, " value"}, ev_v[i], v);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!ended) begin
            ended = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int t0, k, nr, a, g;
        rst_n = 1'b0; req_r = '0; wr_r = '0; done_r = '0; bank_r = '0; row_r = '0;
        clear_log();
        repeat (3) @(negedge clk);
        check("R10 grant in reset", int'(gnt_o), 0);
        check("R10 act in reset", int'(act_o), 0);
        check("R10 pre in reset", int'(pre_o), 0);
        rst_n = 1'b1;
        step();
        check("R10 grant after reset", int'(gnt_o), 0);
        check("R10 pulses after reset", int'(act_o) + int'(pre_o), 0);

        // R2 / R10: closed banks activate with no precharge; R11: then hit directly.
        for (int p = 0; p < NP; p++) begin
            clear_log();
            set_port(p, p, p + 1, p[0]);
            drain();
            exp_ev("R2 act", 0, 1, p);
            exp_ev("R2 grant", 1, 2, p);
            check("R2 act-to-grant gap", ev_c[1] - ev_c[0], AD + 1);
            check("R10 no precharge", n_ev, 2);
            cur_row[p] = p + 1;
            clear_log();
            t0 = cyc;
            set_port(p, p, p + 1, ~p[0]);
            drain();
            exp_ev("R11 direct grant", 0, 2, p);
            check("R11 grant timing", ev_c[0] - t0, 1);
            check("R11 no activate", n_ev, 1);
        end

        // R1: every request mask, all page hits.
        for (int m = 1; m < 16; m++) begin
            clear_log();
            t0 = cyc;
            for (int p = 0; p < NP; p++)
                if (m[p]) set_port(p, p, cur_row[p], m[(p + 1) % 4] ^ p[0]);
            drain();
            k = 0;
            for (int p = 0; p < NP; p++) begin
                if (m[p]) begin
                    exp_ev("R1 order", k, 2, p);
                    check("R1 grant timing", ev_c[k] - t0, 1 + 3 * k);
                    k++;
                end
            end
            check("R1 event count", n_ev, k);
        end

        // R3: row conflict gives precharge, then activate, then grant.
        for (int p = 0; p < NP; p++) begin
            clear_log();
            t0 = cyc;
            nr = cur_row[p] ^ 8;
            set_port(p, p, nr, 1'b1);
            drain();
            exp_ev("R3 pre", 0, 0, p);
            exp_ev("R3 act", 1, 1, p);
            exp_ev("R3 grant", 2, 2, p);
            check("R3 pre timing", ev_c[0] - t0, 1);
            check("R3 pre-to-act gap", ev_c[1] - ev_c[0], PD + 1);
            check("R3 act-to-grant gap", ev_c[2] - ev_c[1], AD + 1);
            cur_row[p] = nr;
        end

        // R5: every ordered pair, lower hit inserted during the activation.
        for (int hi = 0; hi < NP - 1; hi++) begin
            for (int lo = hi + 1; lo < NP; lo++) begin
                clear_log();
                nr = cur_row[hi] ^ 8;
                set_port(hi, hi, nr, 1'b0);
                set_port(lo, lo, cur_row[lo], 1'b1);
                drain();
                exp_ev("R5 pre", 0, 0, hi);
                exp_ev("R5 act", 1, 1, hi);
                exp_ev("R5 inserted grant", 2, 2, lo);
                exp_ev("R5 waiting grant", 3, 2, hi);
                check("R5 insert timing", ev_c[2] - ev_c[1], 2);
                check("R5 waiting timing", ev_c[3] - ev_c[1], imax(5, AD + 1));
                check("R5 event count", n_ev, 4);
                cur_row[hi] = nr;
            end
        end

        // R6: two lower hits, only one inserted.
        clear_log();
        nr = cur_row[0] ^ 8;
        set_port(0, 0, nr, 1'b0);
        set_port(1, 1, cur_row[1], 1'b0);
        set_port(2, 2, cur_row[2], 1'b1);
        drain();
        exp_ev("R6 act", 1, 1, 0);
        exp_ev("R6 single insert", 2, 2, 1);
        exp_ev("R6 waiting served next", 3, 2, 0);
        exp_ev("R6 second lower last", 4, 2, 2);
        check("R6 waiting timing", ev_c[3] - ev_c[1], imax(5, AD + 1));
        cur_row[0] = nr;

        // R7: a higher port with an open row is not inserted.
        clear_log();
        nr = cur_row[1] ^ 8;
        set_port(1, 1, nr, 1'b0);
        g = 0;
        while (n_ev < 2 && g < 30) begin
            step();
            g++;
        end
        set_port(0, 0, cur_row[0], 1'b1);
        drain();
        exp_ev("R7 act", 1, 1, 1);
        exp_ev("R7 waiting port first", 2, 2, 1);
        exp_ev("R7 higher port after", 3, 2, 0);
        check("R7 act-to-grant gap", ev_c[2] - ev_c[1], AD + 1);
        cur_row[1] = nr;

        // R8: a lower port on the bank being opened is not inserted.
        clear_log();
        nr = cur_row[2] ^ 8;
        set_port(0, 2, nr, 1'b0);
        set_port(1, 2, nr, 1'b1);
        drain();
        exp_ev("R8 pre", 0, 0, 2);
        exp_ev("R8 act", 1, 1, 2);
        exp_ev("R8 higher port first", 2, 2, 0);
        exp_ev("R8 same-bank port after", 3, 2, 1);
        check("R8 act-to-grant gap", ev_c[2] - ev_c[1], AD + 1);
        check("R8 event count", n_ev, 4);
        cur_row[2] = nr;

        // R4: done for other ports leaves the grant in place.
        auto_on = 1'b0;
        set_port(3, 3, cur_row[3], 1'b1);
        step();
        step();
        check("R4 grant present", int'(gnt_o), 8);
        done_r = 4'b0111;
        step();
        check("R4 foreign done ignored", int'(gnt_o), 8);
        done_r = 4'b1000;
        req_r[3] = 1'b0;
        step();
        check("R4 own done releases", int'(gnt_o), 0);
        auto_on = 1'b1;
        repeat (2) step();
        a = 0;
        if (!ended) begin
            ended = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule